// File: doc/BRIEF.md
# Scan-Multiplied Low-Resolution Raster Timer

This block produces the sync, blanking and coordinate signals for a low-resolution picture carried inside a standard 1024x768, 60 Hz monitor frame. Its counters run on a pixel clock that is one quarter of the 65 MHz dot clock for that frame, about 16.25 MHz. Each physical line therefore holds 256 wide source pixels.

Vertically, every source row is repeated on several consecutive physical lines. In tripling mode each row appears on three lines, which gives a 256x256 source raster. In quadrupling mode each row appears on four lines, which gives 256x192. The block also sends out a one-clock enable strobe every eighth pixel clock. A processor clocked from that strobe runs at about 2.03 MHz, locked to the video timing.

Memory fetch and colour output belong to other blocks. Those blocks use `disp_en`, `src_col` and `src_row` to address the source picture.

Top module: `scanmul_vga_timer`

## Requirements
- R1: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks (default 336). Within a line, `src_col` counts 0 to H_ACT-1 over the first H_ACT clocks and reads 0 for the rest of the line.
- R2: `hsync_n` is active-low. It is low for exactly the H_SYNC clocks that begin H_ACT+H_FP clocks into the line, and high at every other clock.
- R3: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines (default 806). `vsync_n` is active-low and is low for exactly the V_SYNC lines that begin V_ACT+V_FP lines into the frame.
- R4: `disp_en` is high exactly when the position in the line is below H_ACT and the line number in the frame is below V_ACT.
- R5: In tripling mode (`quad_mode` value 0), `src_row` equals the active line number divided by 3, rounded down.
- R6: In quadrupling mode (`quad_mode` value 1), `src_row` equals the active line number divided by 4, rounded down.
- R7: During vertical blanking, `src_row` holds the last active row, which is (V_ACT-1)/3 or (V_ACT-1)/4 depending on the mode. It returns to 0 at the first line of every frame.
- R8: `quad_mode` is sampled only on the clock that ends a frame, and the sampled value governs the whole next frame. After reset the first frame always uses tripling, and a change of `quad_mode` in the middle of a frame leaves that frame's rows unchanged.
- R9: `cpu_ce` is high for one clock in every CE_DIV clocks (default 8). Its first pulse comes on the CE_DIV-th clock after reset is released.
- R10: While reset is held, the outputs show line position 0 of line 0: `hsync_n`=1, `vsync_n`=1, `disp_en`=1, `src_col`=0, `src_row`=0 and `cpu_ce`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Quarter-rate pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| quad_mode | input | 1 | 0 selects line tripling, 1 selects line quadrupling |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | High in the visible area |
| src_col | output | $clog2(H_ACT) | Source pixel column |
| src_row | output | $clog2(V_ACT/3) | Source row |
| cpu_ce | output | 1 | Processor clock enable, one clock in CE_DIV |

## Verification
The assertions check a set of local rules on every cycle:
- `src_row` and `vsync_n` change only right after a line ends.
- `src_row` returns to 0 after a frame ends.
- Blanking covers the whole horizontal sync.
- `cpu_ce` pulses are single clocks spaced exactly CE_DIV apart.

Only the bench's sweeps can show the absolute positions. The bench runs a reduced configuration through several whole frames and compares every output at every clock with arithmetic predictions. This covers the sync windows, the row numbers under each multiplier, the row held through blanking, and the frame-boundary timing of mode changes.

// File: rtl/svt_pkg.sv
package svt_pkg;

  typedef enum logic {
    MUL3 = 1'b0,
    MUL4 = 1'b1
  } mul_mode_e;

  // Physical lines spent on one source row.
  function automatic int lines_per_row(mul_mode_e m);
    return (m == MUL4) ? 4 : 3;
  endfunction

  // True when pos lies in [lo, lo+len).
  function automatic logic in_window(int pos, int lo, int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

endpackage

// File: rtl/svt_hcount.sv
module svt_hcount #(
  parameter int HT = 336,
  localparam int HW = $clog2(HT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h,
  output logic          line_end
);

  assign line_end = (h == HW'(HT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        h <= '0;
    else if (line_end) h <= '0;
    else               h <= h + 1'b1;
  end

endmodule

// File: rtl/svt_vcount.sv
module svt_vcount
  import svt_pkg::*;
#(
  parameter int VT    = 806,
  parameter int V_ACT = 768,
  parameter int ROW_W = 8,
  localparam int VW   = $clog2(VT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             mode_in,
  output logic [VW-1:0]    v,
  output logic [ROW_W-1:0] row,
  output logic             frame_end
);

  mul_mode_e  mode_q;
  logic [1:0] sub;
  logic [1:0] sub_lim;
  logic       advance;

  assign frame_end = line_end && (v == VW'(VT - 1));
  assign sub_lim   = 2'(lines_per_row(mode_q) - 1);
  // Rows move on only between two active lines.
  assign advance   = line_end && (int'(v) < V_ACT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v      <= '0;
      sub    <= '0;
      row    <= '0;
      mode_q <= MUL3;
    end else if (frame_end) begin
      v      <= '0;
      sub    <= '0;
      row    <= '0;
      mode_q <= mul_mode_e'(mode_in);
    end else if (line_end) begin
      v <= v + 1'b1;
      if (advance) begin
        if (sub == sub_lim) begin
          sub <= '0;
          row <= row + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/svt_cediv.sv
module svt_cediv #(
  parameter int CE_DIV = 8,
  localparam int CW    = (CE_DIV > 1) ? $clog2(CE_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);

  logic [CW-1:0] cnt;

  assign ce = (cnt == CW'(CE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ce) cnt <= '0;
    else         cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/scanmul_vga_timer.sv
module scanmul_vga_timer
  import svt_pkg::*;
#(
  parameter int H_ACT  = 256,
  parameter int H_FP   = 6,
  parameter int H_SYNC = 34,
  parameter int H_BP   = 40,
  parameter int V_ACT  = 768,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 6,
  parameter int V_BP   = 29,
  parameter int CE_DIV = 8,
  localparam int HT    = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int VT    = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int COL_W = $clog2(H_ACT),
  localparam int ROW_W = $clog2(V_ACT / 3),
  localparam int HW    = $clog2(HT),
  localparam int VW    = $clog2(VT)
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             quad_mode,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             disp_en,
  output logic [COL_W-1:0] src_col,
  output logic [ROW_W-1:0] src_row,
  output logic             cpu_ce
);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          line_end;
  logic          frame_end;
  logic          h_vis;
  logic          v_vis;

  svt_hcount #(.HT(HT)) u_h (
    .clk(clk_pix), .rst_n(rst_n), .h(h), .line_end(line_end)
  );

  svt_vcount #(.VT(VT), .V_ACT(V_ACT), .ROW_W(ROW_W)) u_v (
    .clk(clk_pix), .rst_n(rst_n), .line_end(line_end), .mode_in(quad_mode),
    .v(v), .row(src_row), .frame_end(frame_end)
  );

  svt_cediv #(.CE_DIV(CE_DIV)) u_ce (
    .clk(clk_pix), .rst_n(rst_n), .ce(cpu_ce)
  );

  assign h_vis   = int'(h) < H_ACT;
  assign v_vis   = int'(v) < V_ACT;
  assign disp_en = h_vis && v_vis;
  assign src_col = h_vis ? h[COL_W-1:0] : '0;
  assign hsync_n = !in_window(int'(h), H_ACT + H_FP, H_SYNC);
  assign vsync_n = !in_window(int'(v), V_ACT + V_FP, V_SYNC);

endmodule

// File: rtl/svt_checker.sv
module svt_checker #(
  parameter int CE_DIV = 8,
  parameter int ROW_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_end,
  input logic             frame_end,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             disp_en,
  input logic [ROW_W-1:0] src_row,
  input logic             cpu_ce
);

  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (cpu_ce) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  p_row_on_line_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_row) |-> $past(line_end));

  p_row_zero_new_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (src_row == '0));

  p_vsync_on_line_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> $past(line_end));

  p_blank_during_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !disp_en);

  p_ce_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> (gap == 16'(CE_DIV - 1)));

  p_ce_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);

endmodule

bind scanmul_vga_timer svt_checker #(.CE_DIV(CE_DIV), .ROW_W(ROW_W)) u_chk (
  .clk(clk_pix), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
  .src_row(src_row), .cpu_ce(cpu_ce)
);

// File: tb/sim_scanmul_vga_timer.sv
module sim_scanmul_vga_timer;

  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 24, V_FP = 1, V_SYNC = 2, V_BP = 3;
  localparam int CE_DIV = 8;
  localparam int HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FT = HT * VT;
  localparam int FRAMES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic quad_mode = 1'b1;
  logic hsync_n, vsync_n, disp_en, cpu_ce;
  logic [2:0] src_col;
  logic [2:0] src_row;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scanmul_vga_timer #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CE_DIV(CE_DIV)
  ) u0 (
    .clk_pix(clk), .rst_n(rst_n), .quad_mode(quad_mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
    .src_col(src_col), .src_row(src_row), .cpu_ce(cpu_ce)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Mode wanted on the input during each frame; frame 0 is forced to tripling.
  int sched [FRAMES] = '{1, 0, 1, 1, 0, 0};

  initial begin
    int exp_mode;
    int nxt_mode;
    bit switched;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 hsync_n", int'(hsync_n), 1);
    chk("R10 vsync_n", int'(vsync_n), 1);
    chk("R10 disp_en", int'(disp_en), 1);
    chk("R10 src_col", int'(src_col), 0);
    chk("R10 src_row", int'(src_row), 0);
    chk("R10 cpu_ce", int'(cpu_ce), 0);
    rst_n = 1'b1;
    exp_mode = 0;  // R8: reset always starts with tripling
    nxt_mode = 0;
    switched = 1'b0;
    for (int k = 0; k < FRAMES * FT; k++) begin
      int f, hp, ln, vl, n, erow;
      string rtag;
      f  = k / FT;
      hp = k % HT;
      ln = k / HT;
      vl = ln % VT;
      if (hp == 0 && vl == 0 && k > 0) begin
        switched = (nxt_mode != exp_mode);
        exp_mode = nxt_mode;
      end else if (vl != 0) begin
        switched = 1'b0;
      end
      n = (exp_mode == 1) ? 4 : 3;
      erow = (vl < V_ACT) ? vl / n : (V_ACT - 1) / n;
      if (switched)         rtag = "R8 src_row";
      else if (vl >= V_ACT) rtag = "R7 src_row";
      else if (n == 4)      rtag = "R6 src_row";
      else                  rtag = "R5 src_row";
      chk("R1 src_col", int'(src_col), (hp < H_ACT) ? hp : 0);
      chk("R2 hsync_n", int'(hsync_n),
          (hp >= H_ACT + H_FP && hp < H_ACT + H_FP + H_SYNC) ? 0 : 1);
      chk("R3 vsync_n", int'(vsync_n),
          (vl >= V_ACT + V_FP && vl < V_ACT + V_FP + V_SYNC) ? 0 : 1);
      chk("R4 disp_en", int'(disp_en), (hp < H_ACT && vl < V_ACT) ? 1 : 0);
      chk(rtag, int'(src_row), erow);
      chk("R9 cpu_ce", int'(cpu_ce), (k % CE_DIV == CE_DIV - 1) ? 1 : 0);
      // Change the mode mid-frame; R8 says it only takes effect next frame.
      if (hp == HT / 2 && vl == VT / 2) quad_mode = sched[f][0];
      // The edge that ends this frame samples the current input.
      if (hp == HT - 1 && vl == VT - 1) nxt_mode = int'(quad_mode);
      @(negedge clk);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule